// File: doc/BRIEF.md
# Recalibrate Step Pulse Limiter

This block moves a disk drive's head back to track zero. When it is told to start, it issues one step pulse toward the outer track on each step-rate tick. It stops when the drive's track-zero input is seen, or when it has issued a set maximum number of pulses. Two configuration bits select that maximum. One bit widens the track range and the other asks for a long recalibrate. Together they give four limits. The bits are captured when the operation starts.

A successful recalibrate ends with a one-cycle done pulse, and the track register is cleared to zero. If the drive never reports track zero within the limit, the block ends with a one-cycle error pulse and leaves the track register as it was. The track register is read as 12 bits when the wide range was selected at the last start. Otherwise it is read as 8 bits, and the upper four bits read as zero. The direction output points toward track zero for as long as the block is busy.

Top module: `recal_stepper`

## Requirements
- R1: After reset, busy_o, step_o, done_o and err_o are 0, and track_o reads 0x0FF: the register holds all ones, and the 8-bit view applies because the captured wide-range bit resets to 0.
- R2: If trk0_i is 1 in the cycle in which start_i is accepted, done_o pulses in the next cycle, busy_o stays 0 and no step pulse is issued.
- R3: While busy, each cycle in which tick_i is 1 and trk0_i is 0 (and the limit is not used up) produces exactly one step_o pulse, one clock cycle wide, in the following cycle. No step pulse follows a cycle without a tick. dir_o is 1 in every cycle in which busy_o is 1.
- R4: The pulse limit is selected as {wide_i, long_i}: 00 gives 85, 01 gives 255, 10 gives 3925 and 11 gives 4095. After the limit number of pulses, the next tick with trk0_i still 0 ends the operation with err_o and no further pulse.
- R5: trk0_i seen as 1 while busy ends the operation with done_o in the next cycle and no further step pulse. When trk0_i and tick_i are both 1 in the cycle in which the limit is used up, the result is done_o, not err_o.
- R6: A successful end clears the track register to zero. An error end leaves it unchanged. track_o shows all 12 bits when wide_i was 1 at the last accepted start, and otherwise shows only the low 8 bits, with the upper 4 bits reading zero.
- R7: start_i has no effect while busy, and changes on wide_i and long_i after the start have no effect on the running limit.
- R8: done_o and err_o are single-cycle pulses that never coincide, and busy_o is 0 in the cycle in which either of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a recalibrate (accepted only when idle) |
| wide_i | input | 1 | Extended track range select |
| long_i | input | 1 | Long recalibrate select |
| trk0_i | input | 1 | Drive reports head at track zero |
| tick_i | input | 1 | Step-rate tick, one cycle wide |
| step_o | output | 1 | Step pulse to the drive |
| dir_o | output | 1 | Step direction, 1 = toward track zero |
| busy_o | output | 1 | Recalibrate in progress |
| done_o | output | 1 | Pulse: track zero reached |
| err_o | output | 1 | Pulse: limit used up without track zero |
| track_o | output | 12 | Track register view |

## Verification
Two endings can fall in the same cycle. The limit can be used up with a tick pending at the moment the drive reports track zero. The bench provokes this for every configuration: it raises trk0_i right after it has seen the limit-th pulse, while ticks keep arriving every cycle. It then expects done with exactly the limit count of pulses and no error. A second case pairs start_i with an already asserted track zero. There the block must finish without a single pulse, and the bench checks this by counting pulses at the port.

// File: rtl/recal_pkg.sv
package recal_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } recal_state_t;

  // Pick one of four pulse limits from the two configuration bits.
  function automatic int step_limit(input logic wide, input logic lng,
                                    input int lim_std, input int lim_long,
                                    input int lim_wide, input int lim_wide_long);
    case ({wide, lng})
      2'b00:   return lim_std;
      2'b01:   return lim_long;
      2'b10:   return lim_wide;
      default: return lim_wide_long;
    endcase
  endfunction

endpackage

// File: rtl/recal_step_counter.sv
module recal_step_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             at_limit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt == limit);

  // The count never runs past the selected limit.
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !$past(clr)) |-> (cnt <= limit));

endmodule

// File: rtl/recal_seq.sv
module recal_seq
  import recal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic trk0,
  input  logic tick,
  input  logic at_limit,
  output logic busy,
  output logic step,
  output logic done,
  output logic err,
  output logic accept_evt,
  output logic step_evt,
  output logic ok_evt
);

  recal_state_t state;
  logic         fail_evt;

  assign busy       = (state == ST_RUN);
  assign accept_evt = !busy && start;
  assign step_evt   = busy && !trk0 && tick && !at_limit;
  assign fail_evt   = busy && !trk0 && tick && at_limit;
  assign ok_evt     = (accept_evt && trk0) || (busy && trk0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      step <= step_evt;
      done <= ok_evt;
      err  <= fail_evt;
      if (accept_evt && !trk0)     state <= ST_RUN;
      else if (ok_evt || fail_evt) state <= ST_IDLE;
    end
  end

  // A step pulse always answers a tick seen while busy.
  p_step_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> ($past(tick) && $past(busy)));

  // The two endings are exclusive and leave the block idle.
  p_end_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  p_idle_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy);

  // Track zero while running ends the operation successfully.
  p_trk0_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trk0) |=> (done && !step));

endmodule

// File: rtl/recal_stepper.sv
module recal_stepper #(
  parameter int CNT_W         = 12,
  parameter int TRK_W         = 12,
  parameter int TRK_STD_W     = 8,
  parameter int LIM_STD       = 85,
  parameter int LIM_LONG      = 255,
  parameter int LIM_WIDE      = 3925,
  parameter int LIM_WIDE_LONG = 4095
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wide_i,
  input  logic             long_i,
  input  logic             trk0_i,
  input  logic             tick_i,
  output logic             step_o,
  output logic             dir_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [TRK_W-1:0] track_o
);

  localparam int HI_W = TRK_W - TRK_STD_W;

  logic             wide_q, long_q;
  logic [TRK_W-1:0] track_q;
  logic [CNT_W-1:0] limit, cnt;
  logic             at_limit, accept_evt, step_evt, ok_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b0;
      long_q <= 1'b0;
    end else if (accept_evt) begin
      wide_q <= wide_i;
      long_q <= long_i;
    end
  end

  assign limit = CNT_W'(recal_pkg::step_limit(wide_q, long_q, LIM_STD,
                                              LIM_LONG, LIM_WIDE, LIM_WIDE_LONG));

  recal_step_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(accept_evt), .inc(step_evt),
    .limit(limit), .cnt(cnt), .at_limit(at_limit)
  );

  recal_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_i), .trk0(trk0_i), .tick(tick_i),
    .at_limit(at_limit), .busy(busy_o), .step(step_o), .done(done_o),
    .err(err_o), .accept_evt(accept_evt), .step_evt(step_evt), .ok_evt(ok_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      track_q <= '1;
    else if (ok_evt) track_q <= '0;
  end

  assign dir_o   = busy_o;
  assign track_o = wide_q ? track_q : {{HI_W{1'b0}}, track_q[TRK_STD_W-1:0]};

  // The success pulse is seen together with a zero track register.
  p_track_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (track_o == '0));

  // An error only follows a tick taken with the limit already used up.
  p_err_at_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($past(cnt) == $past(limit)));

  // An error ending never touches the track register.
  p_err_keeps_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $stable(track_q));

endmodule

// File: tb/recal_stepper_test.sv
`timescale 1ns/1ps
module recal_stepper_test;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, wide_i = 0, long_i = 0, trk0_i = 0, tick_i = 0;
  logic step_o, dir_o, busy_o, done_o, err_o;
  logic [11:0] track_o;

  int n_run = 0, n_fail = 0, cycles = 0;

  recal_stepper uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
    .long_i(long_i), .trk0_i(trk0_i), .tick_i(tick_i), .step_o(step_o),
    .dir_o(dir_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .track_o(track_o)
  );

  always #2.5 clk = ~clk;

  function automatic int exp_limit(input bit w, input bit l);
    return (w ? 4095 : 255) - (l ? 0 : 170);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // k < 0: track zero never arrives; otherwise it rises after k pulses.
  // gap: a tick every gap cycles. disturb: mid-run config change and start.
  task automatic run(input bit w, input bit l, input int k, input int gap,
                     input bit disturb, output int pulses, output bit got_done,
                     output bit got_err, output int bad);
    int iter = 0;
    bit prev_tick = 0;
    pulses = 0; got_done = 0; got_err = 0; bad = 0;
    @(negedge clk);
    wide_i = w; long_i = l; start_i = 1; trk0_i = (k == 0); tick_i = 0;
    forever begin
      @(negedge clk);
      start_i = 0;
      if (step_o) begin
        pulses++;
        if (!prev_tick) bad++;
      end
      if (busy_o && !dir_o) bad++;
      if ((done_o || err_o) && busy_o) bad++;
      if (done_o && err_o) bad++;
      if (done_o) got_done = 1;
      if (err_o) got_err = 1;
      if (done_o || err_o) break;
      if (k >= 0 && pulses >= k) trk0_i = 1;
      if (disturb && pulses == 3) begin
        wide_i = ~w; long_i = ~l; start_i = 1;
      end
      iter++;
      if (iter > 10000) begin bad++; break; end
      tick_i = ((iter % gap) == 0);
      prev_tick = tick_i;
    end
    tick_i = 0; trk0_i = 0; start_i = 0;
    @(negedge clk);
    check(!done_o && !err_o, "R8 pulse one cycle", done_o + err_o, 0);
  endtask

  initial begin
    int p, bad, lim;
    bit d, e;
    repeat (3) @(negedge clk);
    check(!busy_o && !step_o && !done_o && !err_o, "R1 idle outputs",
          busy_o + step_o + done_o + err_o, 0);
    check(track_o == 12'h0FF, "R1 track reset", track_o, 12'h0FF);
    rst_n = 1;
    @(negedge clk);

    // Error from reset in wide mode: register unchanged, 12-bit view.
    run(1, 1, -1, 1, 0, p, d, e, bad);
    check(e && !d, "R4 error 11", e, 1);
    check(p == 4095, "R4 limit 11", p, 4095);
    check(track_o == 12'hFFF, "R6 error keeps track", track_o, 12'hFFF);
    check(bad == 0, "R3 protocol", bad, 0);

    for (int cfg = 0; cfg < 4; cfg++) begin
      bit w = cfg[1], l = cfg[0];
      lim = exp_limit(w, l);
      run(w, l, 0, 1, 0, p, d, e, bad);
      check(d && !e && p == 0, "R2 already at zero", p, 0);
      check(track_o == 12'h000, "R6 track cleared", track_o, 0);
      run(w, l, 1, 1, 0, p, d, e, bad);
      check(d && p == 1, "R5 zero after one", p, 1);
      run(w, l, lim - 1, 1, 0, p, d, e, bad);
      check(d && !e && p == lim - 1, "R5 zero before limit", p, lim - 1);
      run(w, l, lim, 1, 0, p, d, e, bad);
      check(d && !e && p == lim, "R5 zero with tick at limit", p, lim);
      run(w, l, -1, 1, 0, p, d, e, bad);
      check(e && !d && p == lim, "R4 limit then error", p, lim);
      check(track_o == 12'h000, "R6 error leaves zero", track_o, 0);
      check(bad == 0, "R3 R8 protocol", bad, 0);
    end

    // Sparse ticks: pulses only follow ticks.
    run(0, 0, -1, 3, 0, p, d, e, bad);
    check(e && p == 85 && bad == 0, "R3 sparse ticks", p, 85);

    // Mid-run start and config change must not alter the limit.
    run(0, 0, -1, 1, 1, p, d, e, bad);
    check(e && p == 85, "R7 config latched", p, 85);
    check(bad == 0, "R7 protocol", bad, 0);

    // 8-bit view after narrow run; register still zero.
    run(0, 1, 2, 2, 0, p, d, e, bad);
    check(d && p == 2 && track_o == 0, "R6 narrow view", track_o, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule